// File: doc/BRIEF.md
# Indexed Block-Access SMBus Register Target

This block is an SMBus target that owns a small control and status register file of nine bytes. A host reaches it with indexed block transfers. A write sends an index byte, a byte count and then that many data bytes, which land at consecutive register positions. A read sends the index, turns the bus round with a repeated START and the read address, and then clocks out a count byte followed by register contents from the index onward, for as long as the host keeps acknowledging.

The seven-bit target address is not fixed. It comes from two straps, and each strap can sit at one of three levels, so nine addresses are possible. SCL and SDA are sampled by a fast system clock through synchronisers. SDA is driven open-drain: the block only ever pulls the line low. The register file drives twelve output-enable bits and three control bits, and it reports status inputs, a revision field and fixed identity bytes. A `refclk_ok` input gates the whole interface: while it is low the target ignores the bus.

The controller is a single state machine with these states: S_IDLE, S_GET_ADDR, S_ACK_ADDR, S_GET_INDEX, S_ACK_INDEX, S_GET_COUNT, S_ACK_COUNT, S_GET_DATA, S_ACK_DATA, S_PUT_BYTE, S_GET_HACK and S_SKIP. A START from any state goes to S_GET_ADDR. A STOP goes to S_IDLE, and so does a low `refclk_ok`.

The normal transitions are:
- In S_GET_ADDR, once a byte is complete, a matching address goes to S_ACK_ADDR and any other address goes to S_SKIP.
- From S_ACK_ADDR a write goes to S_GET_INDEX and a read goes to S_PUT_BYTE.
- A write continues S_GET_INDEX to S_ACK_INDEX, S_GET_COUNT, S_ACK_COUNT and S_GET_DATA.
- In S_GET_DATA, if count remains the byte goes to S_ACK_DATA, which returns to S_GET_DATA. If no count remains the byte goes to S_SKIP.
- A read loops S_PUT_BYTE to S_GET_HACK. A host ACK returns to S_PUT_BYTE and a host NACK goes to S_SKIP.

Top module: `smb_idx_regslave`

## Requirements
- R1: After reset SDA is released, all twelve output enables are 1, the three control bits are 3'b011 and the readback count field is 8.
- R2: Each strap is given as a 2-bit level code: 00 low, 01 mid, 10 high, and 11 is taken as high. The pair (A1,A0) selects the 8-bit write address: LL D8, LM DA, LH DE, ML C2, MM C4, MH C6, HL CA, HM CC, HH CE. The read address is the same value with bit 0 set.
- R3: A matching address byte is ACKed. Any other address is NACKed, and SDA then stays released until the next START.
- R4: A block write (index N, count X, data) stores data bytes at N, N+1 and onward and ACKs each one. A data byte after X bytes have been taken is NACKed and discarded.
- R5: A block read (write address, index N, repeated START, read address) returns the count byte first and then register bytes from N, auto-incrementing. It stops after the host NACKs.
- R6: Register contents are:
  - byte 0 = {status[2], status[1], 2'b00, ctrl[2:0], status[0]};
  - byte 1 = enables 7..0;
  - byte 2 = {4'b0, enables 11..8};
  - byte 5 = {rev_id, 4'b0001};
  - byte 6 = 8'hC8;
  - byte 8 = {3'b000, count}.
- R7: Writes to read-only or reserved bytes and bits (bytes 3 to 7, byte 0 bits 7:4 and 0, byte 8 bits 7:5) are ACKed and leave every readback and output unchanged.
- R8: An index above 8 reads as 8'h00, and writes to it are ACKed and ignored.
- R9: A STOP in the middle of a transfer returns the target to idle, and a partially received data byte is not written.
- R10: While `refclk_ok` is low no byte is ACKed and SDA is released.
- R11: The target changes its SDA drive only while SCL is low.
- R12: The count byte sent at the start of every read equals the count field most recently written to byte 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| refclk_ok | input | 1 | High while the reference clock runs; gates the interface |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| strap_a1 | input | 2 | Level code of the upper address strap |
| strap_a0 | input | 2 | Level code of the lower address strap |
| status_in | input | 3 | Read-only status bits reported in byte 0 |
| rev_id | input | 4 | Revision field reported in byte 5 |
| ctrl_out | output | 3 | Read/write control bits of byte 0 (bits 3:1) |
| out_en | output | 12 | Output-enable bits from bytes 1 and 2 |

## Verification
Some properties are checked in every clock cycle inside the RTL:
- SDA drive changes only while the synchronised SCL is low.
- A detected STOP releases SDA and leaves the machine idle.
- A low `refclk_ok` releases SDA on the next cycle.
- The output enables move only in the cycle after a register write strobe.

Other behaviour only shows up in the bench's bus scenarios:
- the address decode across all nine strap settings;
- the count-limited NACK and the count byte that leads each read;
- discarded writes to read-only and out-of-range bytes;
- auto-increment past the last register;
- the write lost by an aborted transfer.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GET_ADDR,
        S_ACK_ADDR,
        S_GET_INDEX,
        S_ACK_INDEX,
        S_GET_COUNT,
        S_ACK_COUNT,
        S_GET_DATA,
        S_ACK_DATA,
        S_PUT_BYTE,
        S_GET_HACK,
        S_SKIP
    } slv_state_t;

    localparam int          REG_COUNT  = 9;
    localparam logic [7:0]  IDX_CTRL   = 8'd0;
    localparam logic [7:0]  IDX_OE_LO  = 8'd1;
    localparam logic [7:0]  IDX_IDENT  = 8'd5;
    localparam logic [7:0]  IDX_DEVICE = 8'd6;
    localparam logic [7:0]  IDX_BCOUNT = 8'd8;

    // level code: 00 low, 01 mid, 10 or 11 high
    function automatic int unsigned level_of(input logic [1:0] code);
        case (code)
            2'b00:   level_of = 0;
            2'b01:   level_of = 1;
            default: level_of = 2;
        endcase
    endfunction

    function automatic logic [7:0] strap_to_addr(input logic [1:0] a1, input logic [1:0] a0);
        int unsigned sel;
        sel = level_of(a1) * 3 + level_of(a0);
        case (sel)
            0:       strap_to_addr = 8'hD8;
            1:       strap_to_addr = 8'hDA;
            2:       strap_to_addr = 8'hDE;
            3:       strap_to_addr = 8'hC2;
            4:       strap_to_addr = 8'hC4;
            5:       strap_to_addr = 8'hC6;
            6:       strap_to_addr = 8'hCA;
            7:       strap_to_addr = 8'hCC;
            default: strap_to_addr = 8'hCE;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_lvl   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_rise  = !scl_d && scl_lvl;
    assign scl_fall  = scl_d && !scl_lvl;
    assign start_det = scl_d && scl_lvl && sda_d && !sda_lvl;
    assign stop_det  = scl_d && scl_lvl && !sda_d && sda_lvl;

endmodule

// File: rtl/smb_strap_decode.sv
module smb_strap_decode (
    input  logic [1:0] strap_a1,
    input  logic [1:0] strap_a0,
    output logic [7:0] my_addr
);
    import smb_regs_pkg::*;

    always_comb my_addr = strap_to_addr(strap_a1, strap_a0);

endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file #(
    parameter int         NUM_OUT  = 12,
    parameter int         CNT_W    = 5,
    parameter logic [2:0] CTRL_RST = 3'b011,
    parameter logic [7:0] DEV_ID   = 8'hC8,
    parameter logic [3:0] VENDOR   = 4'b0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [7:0]         rd_idx,
    input  logic [2:0]         status_in,
    input  logic [3:0]         rev_id,
    output logic [7:0]         rd_data,
    output logic [7:0]         cnt_byte,
    output logic [2:0]         ctrl_out,
    output logic [NUM_OUT-1:0] out_en
);
    import smb_regs_pkg::*;

    localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(REG_COUNT - 1);

    logic [2:0]       ctrl_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            cnt_q  <= CNT_RST;
        end else if (wr_en) begin
            if (wr_idx == IDX_CTRL)   ctrl_q <= wr_data[3:1];
            if (wr_idx == IDX_BCOUNT) cnt_q  <= wr_data[CNT_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_oe
        localparam logic [7:0] BYTE_I = IDX_OE_LO + 8'(g / 8);
        localparam int         BIT_I  = g % 8;
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           bit_q <= 1'b1;
            else if (wr_en && wr_idx == BYTE_I)   bit_q <= wr_data[BIT_I];
        end
        assign out_en[g] = bit_q;
    end

    always_comb begin
        rd_data = 8'h00;
        case (rd_idx)
            IDX_CTRL:   rd_data = {status_in[2], status_in[1], 2'b00, ctrl_q, status_in[0]};
            IDX_IDENT:  rd_data = {rev_id, VENDOR};
            IDX_DEVICE: rd_data = DEV_ID;
            IDX_BCOUNT: rd_data = 8'(cnt_q);
            default:    rd_data = 8'h00;
        endcase
        for (int g = 0; g < NUM_OUT; g++) begin
            if (rd_idx == IDX_OE_LO + 8'(g / 8)) rd_data[g % 8] = out_en[g];
        end
    end

    assign cnt_byte = 8'(cnt_q);
    assign ctrl_out = ctrl_q;

    // R4: enables move only right after a write strobe
    assert_oe_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_en) |-> $past(wr_en));

endmodule

// File: rtl/smb_idx_regslave.sv
module smb_idx_regslave #(
    parameter int NUM_OUT     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               refclk_ok,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [1:0]         strap_a1,
    input  logic [1:0]         strap_a0,
    input  logic [2:0]         status_in,
    input  logic [3:0]         rev_id,
    output logic [2:0]         ctrl_out,
    output logic [NUM_OUT-1:0] out_en
);
    import smb_regs_pkg::*;

    localparam logic [3:0] BYTE_BITS = 4'd8;
    localparam logic [3:0] LAST_TX   = 4'd7;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] my_addr, rd_data, cnt_byte;

    slv_state_t st_q, st_d;
    logic [7:0] sh_q, sh_d, idx_q, idx_d, rem_q, rem_d;
    logic [3:0] cnt_q, cnt_d;
    logic       rd_q, rd_d, hack_q, hack_d, wr_en;
    logic       rx_st, byte_done;

    smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    smb_strap_decode strap_i (
        .strap_a1(strap_a1), .strap_a0(strap_a0), .my_addr(my_addr)
    );

    smb_reg_file #(.NUM_OUT(NUM_OUT)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx_q),
        .wr_data(sh_q), .rd_idx(idx_q), .status_in(status_in),
        .rev_id(rev_id), .rd_data(rd_data), .cnt_byte(cnt_byte),
        .ctrl_out(ctrl_out), .out_en(out_en)
    );

    assign rx_st = (st_q == S_GET_ADDR) || (st_q == S_GET_INDEX) ||
                   (st_q == S_GET_COUNT) || (st_q == S_GET_DATA);
    assign byte_done = scl_fall && (cnt_q == BYTE_BITS);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            sh_q   <= '0;
            idx_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            rd_q   <= 1'b0;
            hack_q <= 1'b1;
        end else begin
            st_q   <= st_d;
            sh_q   <= sh_d;
            idx_q  <= idx_d;
            rem_q  <= rem_d;
            cnt_q  <= cnt_d;
            rd_q   <= rd_d;
            hack_q <= hack_d;
        end
    end

    // transitions and datapath updates
    always_comb begin
        st_d   = st_q;
        sh_d   = sh_q;
        idx_d  = idx_q;
        rem_d  = rem_q;
        cnt_d  = cnt_q;
        rd_d   = rd_q;
        hack_d = hack_q;
        wr_en  = 1'b0;
        if (!refclk_ok) begin
            st_d = S_IDLE;
        end else if (start_det) begin
            st_d  = S_GET_ADDR;
            cnt_d = '0;
        end else if (stop_det) begin
            st_d = S_IDLE;
        end else begin
            if (rx_st && scl_rise && cnt_q != BYTE_BITS) begin
                sh_d  = {sh_q[6:0], sda_lvl};
                cnt_d = cnt_q + 4'd1;
            end
            unique case (st_q)
                S_IDLE, S_SKIP: ;
                S_GET_ADDR: if (byte_done) begin
                    cnt_d = '0;
                    if (sh_q[7:1] == my_addr[7:1]) begin
                        rd_d = sh_q[0];
                        st_d = S_ACK_ADDR;
                    end else begin
                        st_d = S_SKIP;
                    end
                end
                S_GET_INDEX: if (byte_done) begin
                    cnt_d = '0;
                    idx_d = sh_q;
                    st_d  = S_ACK_INDEX;
                end
                S_GET_COUNT: if (byte_done) begin
                    cnt_d = '0;
                    rem_d = sh_q;
                    st_d  = S_ACK_COUNT;
                end
                S_GET_DATA: if (byte_done) begin
                    cnt_d = '0;
                    if (rem_q != 8'd0) begin
                        wr_en = 1'b1;
                        idx_d = idx_q + 8'd1;
                        rem_d = rem_q - 8'd1;
                        st_d  = S_ACK_DATA;
                    end else begin
                        st_d = S_SKIP;
                    end
                end
                S_ACK_ADDR: if (scl_fall) begin
                    cnt_d = '0;
                    if (rd_q) begin
                        sh_d = cnt_byte;
                        st_d = S_PUT_BYTE;
                    end else begin
                        st_d = S_GET_INDEX;
                    end
                end
                S_ACK_INDEX: if (scl_fall) begin
                    cnt_d = '0;
                    st_d  = S_GET_COUNT;
                end
                S_ACK_COUNT, S_ACK_DATA: if (scl_fall) begin
                    cnt_d = '0;
                    st_d  = S_GET_DATA;
                end
                S_PUT_BYTE: if (scl_fall) begin
                    if (cnt_q == LAST_TX) begin
                        cnt_d = '0;
                        st_d  = S_GET_HACK;
                    end else begin
                        sh_d  = {sh_q[6:0], 1'b0};
                        cnt_d = cnt_q + 4'd1;
                    end
                end
                S_GET_HACK: begin
                    if (scl_rise) hack_d = sda_lvl;
                    if (scl_fall) begin
                        if (!hack_q) begin
                            sh_d  = rd_data;
                            idx_d = idx_q + 8'd1;
                            st_d  = S_PUT_BYTE;
                        end else begin
                            st_d = S_SKIP;
                        end
                    end
                end
                default: st_d = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            S_ACK_ADDR, S_ACK_INDEX, S_ACK_COUNT, S_ACK_DATA: sda_oe = 1'b1;
            S_PUT_BYTE: sda_oe = !sh_q[7];
            default:    sda_oe = 1'b0;
        endcase
    end

    // R11: own SDA drive moves only while SCL is low
    assert_sda_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && $past(refclk_ok)) |-> !scl_lvl);

    // R9: a STOP leaves the machine idle with SDA free
    assert_stop_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && refclk_ok) |=> (st_q == S_IDLE));
    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R10: no drive while the reference clock is absent
    assert_refclk_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !refclk_ok |=> !sda_oe);

endmodule

// File: tb/smb_idx_regslave_tb_top.sv
`timescale 1ns/1ps
module smb_idx_regslave_tb_top;

    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n, refclk_ok, scl, sda_h;
    logic        sda_oe, sda_line;
    logic [1:0]  strap_a1, strap_a0;
    logic [2:0]  status_in, ctrl_out;
    logic [3:0]  rev_id;
    logic [11:0] out_en;

    always #2.5 clk = ~clk;

    assign sda_line = sda_h & ~sda_oe;

    smb_idx_regslave dut_i (
        .clk(clk), .rst_n(rst_n), .refclk_ok(refclk_ok), .scl_i(scl),
        .sda_i(sda_line), .sda_oe(sda_oe), .strap_a1(strap_a1),
        .strap_a0(strap_a0), .status_in(status_in), .rev_id(rev_id),
        .ctrl_out(ctrl_out), .out_en(out_en)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] exp_v[$];
    string      exp_tag[$];
    logic [7:0] act_q[$];

    logic [11:0] m_oe;
    logic [2:0]  m_ctrl;
    logic [4:0]  m_cnt;
    logic [7:0]  cur_addr;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_byte(input logic [7:0] i);
        case (i)
            8'd0:    m_byte = {status_in[2], status_in[1], 2'b00, m_ctrl, status_in[0]};
            8'd1:    m_byte = m_oe[7:0];
            8'd2:    m_byte = {4'h0, m_oe[11:8]};
            8'd5:    m_byte = {rev_id, 4'b0001};
            8'd6:    m_byte = 8'hC8;
            8'd8:    m_byte = {3'b000, m_cnt};
            default: m_byte = 8'h00;
        endcase
    endfunction

    task automatic m_write(input logic [7:0] i, input logic [7:0] v);
        case (i)
            8'd0:    m_ctrl = v[3:1];
            8'd1:    m_oe[7:0] = v;
            8'd2:    m_oe[11:8] = v[3:0];
            8'd8:    m_cnt = v[4:0];
            default: ;
        endcase
    endtask

    function automatic logic [7:0] addr_of(input int sel);
        case (sel)
            0: addr_of = 8'hD8; 1: addr_of = 8'hDA; 2: addr_of = 8'hDE;
            3: addr_of = 8'hC2; 4: addr_of = 8'hC4; 5: addr_of = 8'hC6;
            6: addr_of = 8'hCA; 7: addr_of = 8'hCC; default: addr_of = 8'hCE;
        endcase
    endfunction

    function automatic logic [1:0] code_of(input int lvl);
        code_of = (lvl == 0) ? 2'b00 : (lvl == 1) ? 2'b01 : 2'b10;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wbit(input bit b);
        sda_h = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    endtask

    task automatic rbit(output bit b);
        sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_h = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_h = 1'b1; tick(Q);
    endtask

    task automatic send(input logic [7:0] d, output bit ack);
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(ack);
    endtask

    task automatic recv(input bit nack);
        logic [7:0] d;
        bit b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        act_q.push_back(d);
        wbit(nack);
    endtask

    task automatic blk_write(input logic [7:0] idx, input logic [7:0] cnt, input int n,
                             input logic [7:0] d [4], input string req);
        bit a;
        bus_start();
        send(cur_addr, a);  chk(a == 0, "R3 addr ack", a, 0);
        send(idx, a);       chk(a == 0, {req, " index ack"}, a, 0);
        send(cnt, a);       chk(a == 0, {req, " count ack"}, a, 0);
        for (int k = 0; k < n; k++) begin
            send(d[k], a);
            chk(a == ((k < cnt) ? 1'b0 : 1'b1), {req, " data ack"}, a, (k < cnt) ? 0 : 1);
            if (k < cnt) m_write(idx + 8'(k), d[k]);
        end
        bus_stop();
        tick(4);
    endtask

    task automatic blk_read(input logic [7:0] idx, input int n, input string req);
        bit a;
        bus_start();
        send(cur_addr, a);          chk(a == 0, "R3 addr ack", a, 0);
        send(idx, a);               chk(a == 0, {req, " index ack"}, a, 0);
        bus_start();
        send(cur_addr | 8'h01, a);  chk(a == 0, "R5 read addr ack", a, 0);
        exp_v.push_back({3'b000, m_cnt}); exp_tag.push_back("R12 count byte");
        recv(n == 0);
        for (int k = 0; k < n; k++) begin
            exp_v.push_back(m_byte(idx + 8'(k)));
            exp_tag.push_back(req);
            recv(k == n - 1);
        end
        bus_stop();
        tick(4);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() != 0) begin
                logic [7:0] got;
                got = act_q.pop_front();
                if (exp_v.size() == 0) begin
                    chk(1'b0, "R5 unexpected byte", got, 0);
                end else begin
                    logic [7:0] want;
                    string tag;
                    want = exp_v.pop_front();
                    tag  = exp_tag.pop_front();
                    chk(got == want, tag, got, want);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d [4];
        bit a;
        scl = 1'b1; sda_h = 1'b1; refclk_ok = 1'b1;
        strap_a1 = 2'b01; strap_a0 = 2'b01;
        status_in = 3'b101; rev_id = 4'hA;
        rst_n = 1'b0;
        m_oe = 12'hFFF; m_ctrl = 3'b011; m_cnt = 5'd8;
        cur_addr = 8'hC4;
        tick(10);
        rst_n = 1'b1;
        tick(10);

        // R1 reset state
        chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
        chk(out_en == 12'hFFF, "R1 enables", out_en, 12'hFFF);
        chk(ctrl_out == 3'b011, "R1 ctrl", ctrl_out, 3'b011);

        // R5/R6 full default readback
        blk_read(8'd0, 9, "R6 default byte");

        // R4 write two enable bytes
        d = '{8'h5A, 8'h3C, 8'h00, 8'h00};
        blk_write(8'd1, 8'd2, 2, d, "R4");
        chk(out_en == 12'hC5A, "R4 enables after write", out_en, 12'hC5A);
        blk_read(8'd1, 2, "R5 enable readback");

        // R7 read-only and reserved writes
        d = '{8'hFF, 8'h00, 8'h00, 8'h00};
        blk_write(8'd0, 8'd1, 1, d, "R7 byte0");
        chk(ctrl_out == 3'b111, "R7 ctrl bits written", ctrl_out, 3'b111);
        d = '{8'h11, 8'h22, 8'h33, 8'h00};
        blk_write(8'd4, 8'd3, 3, d, "R7 reserved");
        blk_read(8'd0, 9, "R7 readback");

        // R12 count register, R8 beyond end
        d = '{8'hE3, 8'h00, 8'h00, 8'h00};
        blk_write(8'd8, 8'd1, 1, d, "R12");
        blk_read(8'd7, 3, "R8 across end");
        d = '{8'h55, 8'h00, 8'h00, 8'h00};
        blk_write(8'd9, 8'd1, 1, d, "R8");
        chk(out_en == m_oe, "R8 enables untouched", out_en, m_oe);
        blk_read(8'd9, 1, "R8 out of range");

        // R4 byte past count is refused
        d = '{8'h05, 8'h0A, 8'h00, 8'h00};
        blk_write(8'd2, 8'd1, 2, d, "R4 over count");
        chk(out_en[11:8] == 4'h5, "R4 over-count byte discarded", out_en[11:8], 4'h5);

        // R3 wrong address
        bus_start();
        send(8'hD8, a);  chk(a == 1'b1, "R3 mismatch nack", a, 1);
        send(8'h01, a);  chk(a == 1'b1, "R3 ignored after mismatch", a, 1);
        bus_stop(); tick(4);
        chk(out_en == m_oe, "R3 enables untouched", out_en, m_oe);

        // R9 abort in the middle of a data byte
        bus_start();
        send(cur_addr, a); send(8'd1, a); send(8'd1, a);
        for (int i = 0; i < 4; i++) wbit(1'b0);
        bus_stop(); tick(4);
        chk(out_en == m_oe, "R9 partial byte not written", out_en, m_oe);
        chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
        blk_read(8'd1, 1, "R9 readback");

        // R10 reference clock absent
        refclk_ok = 1'b0;
        bus_start();
        send(cur_addr, a); chk(a == 1'b1, "R10 no ack", a, 1);
        bus_stop(); tick(4);
        refclk_ok = 1'b1;
        tick(4);

        // R2 strap decode
        for (int a1 = 0; a1 < 3; a1++) begin
            for (int a0 = 0; a0 < 3; a0++) begin
                strap_a1 = code_of(a1); strap_a0 = code_of(a0);
                tick(4);
                bus_start();
                send(addr_of(a1 * 3 + a0), a);
                chk(a == 1'b0, "R2 strap address ack", a, 0);
                bus_stop(); tick(4);
            end
        end
        strap_a1 = 2'b11; strap_a0 = 2'b11; tick(4);
        bus_start(); send(8'hCE, a); chk(a == 1'b0, "R2 code 11 as high", a, 0);
        bus_stop(); tick(4);

        strap_a1 = 2'b01; strap_a0 = 2'b01; tick(4);
        blk_read(8'd0, 9, "R6 final byte");

        tick(20);
        chk(exp_v.size() == 0, "R5 all expected bytes seen", exp_v.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule